// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is the command front end of an embedded NOR flash controller. It watches 32-bit writes that land in the flash address window and decodes them as multi-step unlock sequences made of address/data pairs at fixed offsets. The recognised commands are sector erase, user-block erase, enter page mode, page buffer load, page write, clear status and temporary unprotect. The command code sits in bits 7:0 of the write data. The upper bits are ignored for command codes. They are used in full for the passwords and the user level.

The result of every command is visible in a 32-bit status word that software polls. A parameterised cycle counter stands in for the program and erase time of the array, so the busy flag rises when an operation starts and falls after a known number of cycles. A write that breaks a sequence, or that arrives while the block is busy, does not run any operation. It sets a sticky sequence-error flag instead, and that flag stays set until a clear-status command. A program or erase aimed at a locked sector sets a sticky protection-error flag. The sector is the address bits above `SECT_W`. The lock check is skipped once a temporary unprotect with the right passwords has been accepted.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the status word is 0.
- R2: An erase runs on six writes: 0x5554/AA, 0xAAA8/55, 0x5554/80, 0x5554/AA, 0xAAA8/55, then the sector address/30. For an unlocked sector this sets status bit 5 (erase) and bit 0 (busy). Busy stays high for exactly OP_CYCLES cycles. Bit 5 is still set after busy falls.
- R3: If the last erase write carries 0xC0 instead of 0x30, a user configuration block is erased. This starts an erase (bits 5 and 0) even when the addressed sector is locked.
- R4: Writing 0x50 to 0x5554 sets the page-mode flag, status bit 6. It also empties the pair count.
- R5: A page write runs on 0x5554/AA, 0xAAA8/55, 0x5554/A0 (or C0 for the user area), then the page address/AA. It needs page mode and exactly PAGE_PAIRS full pairs, each made of a low word at 0x55F0 followed by a high word at 0x55F4. When these hold, it sets bit 4 (program) and bit 0 (busy), and it clears bit 6.
- R6: Each of the following sets bit 10 (sequence error) and starts no operation: a page write without page mode, a page write with fewer than PAGE_PAIRS pairs, and a high word written without a pending low word.
- R7: A write that does not fit the current sequence step sets bit 10 and returns the decoder to idle. A full valid sequence that follows still runs, and bit 10 stays set.
- R8: Writing 0xF5 to 0x5554 clears bits 4, 5, 6, 10 and 11. Bit 25 keeps its value.
- R9: Any write while busy is ignored and sets bit 10. The running operation keeps its full OP_CYCLES busy time.
- R10: A program or sector erase aimed at a locked sector sets bit 11 (protection error) and starts nothing, unless bit 25 is set. A refused page write leaves page mode set.
- R11: The temporary unprotect runs on 0x5554/AA, 0xAAA8/55, 0x553C/level, 0xAAA8/password 1, 0xAAA8/password 2, 0x5558/05. For level 0 with both passwords correct it sets bit 25. A level 1 or 2 match changes nothing. A wrong password sets bit 11. A level above 2 sets bit 10.
- R12: A low word written after PAGE_PAIRS pairs are already loaded sets bit 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Write strobe into the flash window |
| wr_addr_i | input | ADDR_W | Byte offset of the write within the window |
| wr_data_i | input | 32 | Write data; command code in bits 7:0 |
| sector_lock_i | input | 2**(ADDR_W-SECT_W) | One lock bit per sector |
| status_o | output | 32 | Status word (bits 0, 4, 5, 6, 10, 11, 25) |

## Verification
The erase sequence is swept over every sector against a mixed lock pattern, so each sector's outcome (erase versus protection error) shows whether the sector index and lock lookup are right. Page writes are tried with 0, 1, 31, 32 and 33 loaded pairs, without page mode, and with an orphan high word, which separates the pair-count boundary from the ordering rules. Broken sequences, writes during busy, and the unprotect with right and wrong passwords and levels show that errors are sticky, that they do not disturb a running operation, and that the lock bypass applies only after a level-0 match.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    // Unlock offsets within the window
    localparam logic [15:0] OFF_UNL_A  = 16'h5554;
    localparam logic [15:0] OFF_UNL_B  = 16'hAAA8;
    localparam logic [15:0] OFF_LOAD_L = 16'h55F0;
    localparam logic [15:0] OFF_LOAD_H = 16'h55F4;
    localparam logic [15:0] OFF_LEVEL  = 16'h553C;
    localparam logic [15:0] OFF_FINAL  = 16'h5558;

    // Command codes (data bits 7:0)
    localparam logic [7:0] CMD_AA    = 8'hAA;
    localparam logic [7:0] CMD_55    = 8'h55;
    localparam logic [7:0] CMD_ERASE = 8'h80;
    localparam logic [7:0] CMD_SECT  = 8'h30;
    localparam logic [7:0] CMD_USER  = 8'hC0;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_PAGE  = 8'h50;
    localparam logic [7:0] CMD_CLR   = 8'hF5;
    localparam logic [7:0] CMD_UNP   = 8'h05;

    // Status bit positions
    localparam int unsigned SB_BUSY   = 0;
    localparam int unsigned SB_PROG   = 4;
    localparam int unsigned SB_ERASE  = 5;
    localparam int unsigned SB_PAGE   = 6;
    localparam int unsigned SB_SEQERR = 10;
    localparam int unsigned SB_PROERR = 11;
    localparam int unsigned SB_UNPROT = 25;

    typedef enum logic [3:0] {
        ST_IDLE, ST_U1, ST_U2,
        ST_E3, ST_E4, ST_E5,
        ST_W3,
        ST_P3, ST_P4, ST_P5
    } seq_state_e;

    // One-cycle events from the decoder
    typedef struct packed {
        logic clr;
        logic seq_err;
        logic pro_err;
        logic prog_go;
        logic erase_go;
        logic unl_ok;
    } seq_ev_t;

endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int unsigned OP_CYCLES = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o
);
    localparam int unsigned CNT_W = $clog2(OP_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (start_i) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(OP_CYCLES);
        end else if (q.busy) begin
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
            end
            d.cnt = q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;

    // R2
    busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.busy && q.cnt == CNT_W'(1) && !start_i) |=> !q.busy);

    // R9
    no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> !q.busy);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned SECT_W     = 14,
    parameter int unsigned PAGE_PAIRS = 32,
    parameter logic [31:0] PW1        = 32'h1234_5678,
    parameter logic [31:0] PW2        = 32'h9ABC_DEF0
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            wr_addr_i,
    input  logic [31:0]                  wr_data_i,
    input  logic [2**(ADDR_W-SECT_W)-1:0] sector_lock_i,
    input  logic                         busy_i,
    input  logic                         unprot_i,
    output seq_ev_t                      ev_o,
    output logic                         page_o
);
    localparam int unsigned NSECT  = 2 ** (ADDR_W - SECT_W);
    localparam int unsigned PAIR_W = $clog2(PAGE_PAIRS + 1);
    localparam logic [ADDR_W-1:0] A_UNL_A  = ADDR_W'(OFF_UNL_A);
    localparam logic [ADDR_W-1:0] A_UNL_B  = ADDR_W'(OFF_UNL_B);
    localparam logic [ADDR_W-1:0] A_LOAD_L = ADDR_W'(OFF_LOAD_L);
    localparam logic [ADDR_W-1:0] A_LOAD_H = ADDR_W'(OFF_LOAD_H);
    localparam logic [ADDR_W-1:0] A_LEVEL  = ADDR_W'(OFF_LEVEL);
    localparam logic [ADDR_W-1:0] A_FINAL  = ADDR_W'(OFF_FINAL);

    typedef struct packed {
        seq_state_e        st;
        logic              page;
        logic              half;
        logic [PAIR_W-1:0] pairs;
        logic              user;
        logic [1:0]        level;
        logic              pw1ok;
    } dec_t;

    dec_t d, q;

    logic [7:0]  code;
    logic        at_a, at_b;
    logic        locked;
    logic [$clog2(NSECT)-1:0] sect;

    assign code   = wr_data_i[7:0];
    assign at_a   = (wr_addr_i == A_UNL_A);
    assign at_b   = (wr_addr_i == A_UNL_B);
    assign sect   = wr_addr_i[ADDR_W-1:SECT_W];
    assign locked = sector_lock_i[sect] && !unprot_i;

    always_comb begin
        d    = q;
        ev_o = '0;
        if (wr_en_i && busy_i) begin
            ev_o.seq_err = 1'b1;
        end else if (wr_en_i) begin
            d.st = ST_IDLE;
            unique case (q.st)
                ST_IDLE: begin
                    if (at_a && code == CMD_AA) begin
                        d.st = ST_U1;
                    end else if (at_a && code == CMD_PAGE) begin
                        d.page  = 1'b1;
                        d.half  = 1'b0;
                        d.pairs = '0;
                    end else if (at_a && code == CMD_CLR) begin
                        ev_o.clr = 1'b1;
                        d.page   = 1'b0;
                        d.half   = 1'b0;
                        d.pairs  = '0;
                    end else if (wr_addr_i == A_LOAD_L && q.page && !q.half
                                 && q.pairs < PAIR_W'(PAGE_PAIRS)) begin
                        d.half = 1'b1;
                    end else if (wr_addr_i == A_LOAD_H && q.page && q.half) begin
                        d.half  = 1'b0;
                        d.pairs = q.pairs + PAIR_W'(1);
                    end else begin
                        ev_o.seq_err = 1'b1;
                    end
                end
                ST_U1: begin
                    if (at_b && code == CMD_55) d.st = ST_U2;
                    else ev_o.seq_err = 1'b1;
                end
                ST_U2: begin
                    if (at_a && code == CMD_ERASE) begin
                        d.st = ST_E3;
                    end else if (at_a && (code == CMD_PROG || code == CMD_USER)) begin
                        d.st   = ST_W3;
                        d.user = (code == CMD_USER);
                    end else if (wr_addr_i == A_LEVEL && wr_data_i < 32'd3) begin
                        d.st    = ST_P3;
                        d.level = wr_data_i[1:0];
                    end else begin
                        ev_o.seq_err = 1'b1;
                    end
                end
                ST_E3: begin
                    if (at_a && code == CMD_AA) d.st = ST_E4;
                    else ev_o.seq_err = 1'b1;
                end
                ST_E4: begin
                    if (at_b && code == CMD_55) d.st = ST_E5;
                    else ev_o.seq_err = 1'b1;
                end
                ST_E5: begin
                    if (code == CMD_USER) begin
                        ev_o.erase_go = 1'b1;
                    end else if (code == CMD_SECT) begin
                        if (locked) ev_o.pro_err  = 1'b1;
                        else        ev_o.erase_go = 1'b1;
                    end else begin
                        ev_o.seq_err = 1'b1;
                    end
                end
                ST_W3: begin
                    if (code != CMD_AA || !q.page || q.half
                        || q.pairs != PAIR_W'(PAGE_PAIRS)) begin
                        ev_o.seq_err = 1'b1;
                    end else if (!q.user && locked) begin
                        ev_o.pro_err = 1'b1;
                    end else begin
                        ev_o.prog_go = 1'b1;
                        d.page  = 1'b0;
                        d.pairs = '0;
                    end
                end
                ST_P3: begin
                    if (at_b) begin
                        d.st    = ST_P4;
                        d.pw1ok = (wr_data_i == PW1);
                    end else begin
                        ev_o.seq_err = 1'b1;
                    end
                end
                ST_P4: begin
                    if (at_b) begin
                        d.st    = ST_P5;
                        d.pw1ok = q.pw1ok && (wr_data_i == PW2);
                    end else begin
                        ev_o.seq_err = 1'b1;
                    end
                end
                ST_P5: begin
                    if (wr_addr_i == A_FINAL && code == CMD_UNP) begin
                        if (!q.pw1ok)            ev_o.pro_err = 1'b1;
                        else if (q.level == 2'd0) ev_o.unl_ok  = 1'b1;
                    end else begin
                        ev_o.seq_err = 1'b1;
                    end
                end
                default: ev_o.seq_err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign page_o = q.page;

    // R5
    prog_leaves_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_o.prog_go |=> !page_o);

    // R12
    pairs_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.pairs <= PAIR_W'(PAGE_PAIRS));

    // R9
    busy_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && busy_i) |=> $stable(q));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned SECT_W     = 14,
    parameter int unsigned PAGE_PAIRS = 32,
    parameter int unsigned OP_CYCLES  = 20,
    parameter logic [31:0] PW1        = 32'h1234_5678,
    parameter logic [31:0] PW2        = 32'h9ABC_DEF0
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             wr_addr_i,
    input  logic [31:0]                   wr_data_i,
    input  logic [2**(ADDR_W-SECT_W)-1:0] sector_lock_i,
    output logic [31:0]                   status_o
);
    typedef struct packed {
        logic prog;
        logic erase;
        logic seqerr;
        logic proerr;
        logic unprot;
    } flags_t;

    flags_t  d, q;
    seq_ev_t ev;
    logic    busy;
    logic    page;

    flash_cmd_decoder #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PAGE_PAIRS(PAGE_PAIRS),
        .PW1(PW1), .PW2(PW2)
    ) dec_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .sector_lock_i(sector_lock_i),
        .busy_i(busy), .unprot_i(q.unprot),
        .ev_o(ev), .page_o(page)
    );

    flash_op_timer #(.OP_CYCLES(OP_CYCLES)) tmr_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .start_i(ev.prog_go || ev.erase_go),
        .busy_o(busy)
    );

    always_comb begin
        d = q;
        if (ev.clr) begin
            d.prog   = 1'b0;
            d.erase  = 1'b0;
            d.seqerr = 1'b0;
            d.proerr = 1'b0;
        end
        if (ev.seq_err)  d.seqerr = 1'b1;
        if (ev.pro_err)  d.proerr = 1'b1;
        if (ev.prog_go)  d.prog   = 1'b1;
        if (ev.erase_go) d.erase  = 1'b1;
        if (ev.unl_ok)   d.unprot = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        status_o            = '0;
        status_o[SB_BUSY]   = busy;
        status_o[SB_PROG]   = q.prog;
        status_o[SB_ERASE]  = q.erase;
        status_o[SB_PAGE]   = page;
        status_o[SB_SEQERR] = q.seqerr;
        status_o[SB_PROERR] = q.proerr;
        status_o[SB_UNPROT] = q.unprot;
    end

    // R7
    seqerr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.seqerr && !ev.clr) |=> q.seqerr);

    // R8
    clear_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev.clr |=> (status_o[11:4] == 8'h00));

    // R2
    busy_has_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy) |-> (q.prog || q.erase));

    // R10
    refused_no_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev.pro_err && !busy) |=> !busy);

endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
    localparam int unsigned ADDR_W = 18;
    localparam int unsigned SECT_W = 14;
    localparam int unsigned PAIRS  = 32;
    localparam int unsigned OPC    = 20;
    localparam logic [31:0] PWA    = 32'h1234_5678;
    localparam logic [31:0] PWB    = 32'h9ABC_DEF0;

    localparam logic [31:0] B_BUSY = 32'h1;
    localparam logic [31:0] B_PROG = 32'h10;
    localparam logic [31:0] B_ERAS = 32'h20;
    localparam logic [31:0] B_PAGE = 32'h40;
    localparam logic [31:0] B_SEQ  = 32'h400;
    localparam logic [31:0] B_PRO  = 32'h800;
    localparam logic [31:0] B_UNP  = 32'h0200_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [15:0]       lock = 16'hA5C3;
    logic [31:0]       status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    flash_cmd_seq #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PAGE_PAIRS(PAIRS),
        .OP_CYCLES(OPC), .PW1(PWA), .PW2(PWB)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .sector_lock_i(lock), .status_o(status)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act %0d cycles exp < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] dt);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = dt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_st();
        wr(18'h05554, 32'hF5);
    endtask

    task automatic erase(input logic [ADDR_W-1:0] a, input logic [7:0] last);
        wr(18'h05554, 32'hAA); wr(18'h0AAA8, 32'h55); wr(18'h05554, 32'h80);
        wr(18'h05554, 32'hAA); wr(18'h0AAA8, 32'h55); wr(a, {24'h0, last});
    endtask

    task automatic prog(input logic [ADDR_W-1:0] a, input logic [7:0] kind);
        wr(18'h05554, 32'hAA); wr(18'h0AAA8, 32'h55); wr(18'h05554, {24'h0, kind});
        wr(a, 32'hAA);
    endtask

    task automatic load(input int n);
        for (int i = 0; i < n; i++) begin
            wr(18'h055F0, i);
            wr(18'h055F4, ~i);
        end
    endtask

    task automatic unprot(input logic [31:0] lvl, input logic [31:0] p1, input logic [31:0] p2);
        wr(18'h05554, 32'hAA); wr(18'h0AAA8, 32'h55); wr(18'h0553C, lvl);
        wr(18'h0AAA8, p1); wr(18'h0AAA8, p2); wr(18'h05558, 32'h05);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (status[0] === 1'b1 && n < 1000) begin
            n = n + 1;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        logic [31:0] base;
        @(negedge clk);
        chk("R1 status in reset", status, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after reset", status, 32'h0);

        // R2 / R10: erase sweep over every sector against the lock pattern
        for (int s = 0; s < 16; s++) begin
            clear_st();
            erase(18'(s) << SECT_W, 8'h30);
            if (lock[s]) begin
                chk($sformatf("R10 erase locked sector %0d", s), status, B_PRO);
            end else begin
                chk($sformatf("R2 erase start sector %0d", s), status, B_BUSY | B_ERAS);
                busy_len(n);
                chk($sformatf("R2 busy length sector %0d", s), n, OPC);
                chk($sformatf("R2 erase done sector %0d", s), status, B_ERAS);
            end
        end

        // R3: user block erase ignores lock (sector 0 is locked)
        clear_st();
        erase(18'h00000, 8'hC0);
        chk("R3 user block erase", status, B_BUSY | B_ERAS);
        busy_len(n);

        // R4 / R5: page program of unlocked sector 2
        clear_st();
        wr(18'h05554, 32'h50);
        chk("R4 page mode entered", status, B_PAGE);
        load(PAIRS);
        chk("R4 page mode after full load", status, B_PAGE);
        prog(18'h08000, 8'hA0);
        chk("R5 program start", status, B_BUSY | B_PROG);
        busy_len(n);
        chk("R5 program busy length", n, OPC);
        chk("R5 program done", status, B_PROG);

        // R5: user-area page write into a locked sector is allowed
        clear_st();
        wr(18'h05554, 32'h50);
        load(PAIRS);
        prog(18'h00100, 8'hC0);
        chk("R5 user area program", status, B_BUSY | B_PROG);
        busy_len(n);

        // R6: too few pairs (0, 1, 31)
        foreach (base[k]) begin end
        for (int t = 0; t < 3; t++) begin
            int np;
            np = (t == 0) ? 0 : (t == 1) ? 1 : PAIRS - 1;
            clear_st();
            wr(18'h05554, 32'h50);
            load(np);
            prog(18'h08000, 8'hA0);
            chk($sformatf("R6 program with %0d pairs", np), status, B_PAGE | B_SEQ);
        end

        // R6: no page mode
        clear_st();
        prog(18'h08000, 8'hA0);
        chk("R6 program without page mode", status, B_SEQ);

        // R6: high word without low word
        clear_st();
        wr(18'h05554, 32'h50);
        wr(18'h055F4, 32'h1);
        chk("R6 orphan high word", status, B_PAGE | B_SEQ);

        // R12: one pair too many
        clear_st();
        wr(18'h05554, 32'h50);
        load(PAIRS);
        chk("R12 full load no error", status, B_PAGE);
        wr(18'h055F0, 32'h7);
        chk("R12 extra low word", status, B_PAGE | B_SEQ);

        // R10: program into locked sector 0
        clear_st();
        wr(18'h05554, 32'h50);
        load(PAIRS);
        prog(18'h00200, 8'hA0);
        chk("R10 program locked sector", status, B_PAGE | B_PRO);

        // R7: broken sequence then valid erase
        clear_st();
        wr(18'h05554, 32'hAA); wr(18'h0AAA8, 32'h55); wr(18'h05554, 32'h99);
        chk("R7 broken sequence", status, B_SEQ);
        erase(18'h08000, 8'h30);
        chk("R7 valid erase after break", status, B_SEQ | B_BUSY | B_ERAS);
        busy_len(n);

        // R9: write during busy
        clear_st();
        erase(18'h08000, 8'h30);
        n = 1;
        wr(18'h05554, 32'hF5);
        begin
            int m;
            busy_len(m);
            n = n + m;
        end
        chk("R9 busy length with intruding write", n, OPC);
        chk("R9 intruding write flagged", status, B_ERAS | B_SEQ);

        // R8: clear status
        wr(18'h05554, 32'h50);
        wr(18'h05554, 32'hF5);
        chk("R8 clear status", status, 32'h0);

        // R11: unprotect variants
        unprot(32'd0, PWA, ~PWB);
        chk("R11 wrong password", status, B_PRO);
        clear_st();
        unprot(32'd3, PWA, PWB);
        chk("R11 level above 2", status, B_SEQ);
        clear_st();
        unprot(32'd1, PWA, PWB);
        chk("R11 level 1 match no flag", status, 32'h0);
        unprot(32'd0, PWA, PWB);
        chk("R11 level 0 unprotect", status, B_UNP);
        erase(18'h00000, 8'h30);
        chk("R11 locked erase after unprotect", status, B_UNP | B_BUSY | B_ERAS);
        busy_len(n);
        clear_st();
        chk("R8 clear keeps unprotect", status, B_UNP);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule